// File: doc/BRIEF.md
# Address-Masked GPIO Data Port

This block is an eight-pin general-purpose I/O port that sits behind a simple register-bus slave. Its data window is special. The byte-address bits just above the word offset act as a per-pin mask. Software can therefore drive any subset of pins high or low in one write, with no read-modify-write. It can also read back any subset of pin levels, with the other bits forced to zero.

A direction register sits outside the data window and chooses, pin by pin, whether the port drives the pin. Pin inputs pass through a two-flop synchronizer before they reach the read path. For a pin configured as an output, a read returns the level the port is driving. Read data is registered and appears one cycle after the read is presented. The read returns the state from before any write issued in the same cycle.

Top module: `mgpio_port`

## Requirements
- R1: During and right after reset, pin_out is 0x00, pin_oe is 0x00 (all pins inputs) and bus_rdata is 0.
- R2: A write with byte-address bits [11:10] equal to 0 targets the data window. Address bits [9:2] form the pin mask, with mask bit i selecting pin i and wdata bit i carrying the value for pin i. Each selected pin's output register takes that written value. Unselected pins keep their previous value.
- R3: A data-window read returns zero in every bit whose mask bit is 0.
- R4: In a data-window read, a bit whose mask bit is 1 returns the pin level. For a pin with direction bit 1, the level is the driven output value. For a pin with direction bit 0, the level is the synchronized input.
- R5: The direction register is at byte address 0x400, and bit i set to 1 makes pin i an output. pin_oe equals the direction register at all times, the register reads back at 0x400, and a write there takes wdata[7:0].
- R6: A pin_in change first captured at clock edge k is returned by a read sampled at edge k+2 or later. Reads sampled at edges k and k+1 still return the old level.
- R7: Writes to addresses outside the data window and the direction register change neither pin_out nor pin_oe, and reads from those addresses return 0. Examples of such addresses are 0x404, 0x800 and 0xFFC.
- R8: Read data is valid in the cycle after the read request. It is 0 after a cycle with no read. A read and a write in the same cycle at the same address return the value from before the write.
- R9: Byte-address bits [1:0] are ignored, and bus_rdata bits [31:8] always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the bus access |
| bus_we | input | 1 | Write request for this cycle |
| bus_re | input | 1 | Read request for this cycle |
| bus_wdata | input | 32 | Write data; bits [7:0] are used |
| bus_rdata | output | 32 | Registered read data, one cycle after bus_re |
| pin_in | input | 8 | Asynchronous pin input levels |
| pin_out | output | 8 | Output drive value per pin |
| pin_oe | output | 8 | Output enable per pin (1 = driven) |

## Verification
Two functions can land in one clock cycle. The first is a read and a write of the data window at the same address. The second is a pin input transition together with a read of that pin.

The first case is provoked by raising bus_re and bus_we together on a full-mask address. The scoreboard expects the pre-write pin state, computed from the bench's model before the model applies the write.

The second case changes pin_in just before the edge that samples a read, then reads again on the next two edges. The expected old, old, then new sequence is queued and compared by the monitor.

// File: rtl/mgpio_pkg.sv
package mgpio_pkg;

   // Decoded kind of the current bus access
   typedef struct packed {
      logic win_wr;
      logic win_rd;
      logic dir_wr;
      logic dir_rd;
   } mgpio_acc_t;

   // Lowest byte-address bit used as a pin mask bit (word aligned bus)
   localparam int unsigned MGPIO_MASK_LSB = 2;

endpackage

// File: rtl/mgpio_sync.sv
module mgpio_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (WIDTH < 1) begin : g_bad_width
      $error("mgpio_sync: WIDTH must be at least 1");
   end

   if (STAGES == 0) begin : g_bypass
      assign q = d;
   end else begin : g_chain
      logic [WIDTH-1:0] stg_q [STAGES];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
         end else begin
            stg_q[0] <= d;
            for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
         end
      end

      assign q = stg_q[STAGES-1];
   end

endmodule

// File: rtl/mgpio_decode.sv
module mgpio_decode
   import mgpio_pkg::*;
#(
   parameter int unsigned        ADDR_W   = 12,
   parameter int unsigned        PIN_W    = 8,
   parameter logic [ADDR_W-1:0]  DIR_ADDR = 12'h400
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   input  logic              re,
   output mgpio_acc_t        acc,
   output logic [PIN_W-1:0]  mask
);

   localparam int unsigned WIN_BITS = PIN_W + MGPIO_MASK_LSB;

   if (WIN_BITS >= ADDR_W) begin : g_bad_aw
      $error("mgpio_decode: ADDR_W too small for the data window");
   end
   if (DIR_ADDR < (ADDR_W'(1) << WIN_BITS)) begin : g_bad_dir
      $error("mgpio_decode: DIR_ADDR overlaps the data window");
   end

   logic win_hit;
   logic dir_hit;
   logic unused_lsbs;

   assign win_hit     = (addr[ADDR_W-1:WIN_BITS] == '0);
   assign dir_hit     = (addr[ADDR_W-1:MGPIO_MASK_LSB] == DIR_ADDR[ADDR_W-1:MGPIO_MASK_LSB]);
   assign mask        = addr[WIN_BITS-1:MGPIO_MASK_LSB];
   assign unused_lsbs = ^addr[MGPIO_MASK_LSB-1:0];    // R9: byte lanes ignored

   always_comb begin
      acc        = '0;
      acc.win_wr = we && win_hit;
      acc.win_rd = re && win_hit;
      acc.dir_wr = we && dir_hit;
      acc.dir_rd = re && dir_hit;
   end

endmodule

// File: rtl/mgpio_regs.sv
module mgpio_regs
   import mgpio_pkg::*;
#(
   parameter int unsigned PIN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  mgpio_acc_t       acc,
   input  logic [PIN_W-1:0] mask,
   input  logic [PIN_W-1:0] wdata,
   output logic [PIN_W-1:0] out_q,
   output logic [PIN_W-1:0] dir_q
);

   // Per-pin output bit: updated only when its mask bit selects it
   for (genvar i = 0; i < PIN_W; i++) begin : g_pin
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                      out_q[i] <= 1'b0;
         else if (acc.win_wr && mask[i])  out_q[i] <= wdata[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          dir_q <= '0;
      else if (acc.dir_wr) dir_q <= wdata;
   end

   AST_MASKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      acc.win_wr |=> (((out_q ^ $past(wdata)) & $past(mask)) == '0));           // R2
   AST_UNMASKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      acc.win_wr |=> (((out_q ^ $past(out_q)) & ~$past(mask)) == '0));          // R2
   AST_OUT_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !acc.win_wr |=> $stable(out_q));                                          // R7
   AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !acc.dir_wr |=> $stable(dir_q));                                          // R5

endmodule

// File: rtl/mgpio_port.sv
module mgpio_port
   import mgpio_pkg::*;
#(
   parameter int unsigned       ADDR_W      = 12,
   parameter int unsigned       DATA_W      = 32,
   parameter int unsigned       PIN_W       = 8,
   parameter int unsigned       SYNC_STAGES = 2,
   parameter logic [ADDR_W-1:0] DIR_ADDR    = 12'h400
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic              bus_re,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [PIN_W-1:0]  pin_in,
   output logic [PIN_W-1:0]  pin_out,
   output logic [PIN_W-1:0]  pin_oe
);

   if (PIN_W > DATA_W) begin : g_bad_pins
      $error("mgpio_port: PIN_W exceeds DATA_W");
   end

   mgpio_acc_t       acc;
   logic [PIN_W-1:0] mask;
   logic [PIN_W-1:0] out_q;
   logic [PIN_W-1:0] dir_q;
   logic [PIN_W-1:0] in_sync;
   logic [PIN_W-1:0] level;
   logic [DATA_W-1:0] rdata_d;
   logic [DATA_W-1:0] rdata_q;

   mgpio_decode #(.ADDR_W(ADDR_W), .PIN_W(PIN_W), .DIR_ADDR(DIR_ADDR)) decode_i (
      .addr (bus_addr),
      .we   (bus_we),
      .re   (bus_re),
      .acc  (acc),
      .mask (mask)
   );

   mgpio_regs #(.PIN_W(PIN_W)) regs_i (
      .clk   (clk),
      .rst_n (rst_n),
      .acc   (acc),
      .mask  (mask),
      .wdata (bus_wdata[PIN_W-1:0]),
      .out_q (out_q),
      .dir_q (dir_q)
   );

   mgpio_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (in_sync)
   );

   if (DATA_W > PIN_W) begin : g_wide_bus
      logic unused_wdata_hi;
      assign unused_wdata_hi = ^bus_wdata[DATA_W-1:PIN_W];
   end

   // Output pins read their driven value, input pins the synchronized level
   assign level = (dir_q & out_q) | (~dir_q & in_sync);

   always_comb begin
      rdata_d = '0;
      if (acc.win_rd)      rdata_d[PIN_W-1:0] = level & mask;
      else if (acc.dir_rd) rdata_d[PIN_W-1:0] = dir_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rdata_q <= '0;
      else        rdata_q <= rdata_d;
   end

   assign bus_rdata = rdata_q;
   assign pin_out   = out_q;
   assign pin_oe    = dir_q;

   AST_RD_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      acc.win_rd |=> ((bus_rdata[PIN_W-1:0] & ~$past(mask)) == '0));            // R3
   AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_re |=> (bus_rdata == '0));                                           // R8
   AST_RD_UNMAPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_re && !acc.win_rd && !acc.dir_rd) |=> (bus_rdata == '0));            // R7
   AST_RD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rdata >> PIN_W) == '0);                                              // R9

endmodule

// File: tb/mgpio_port_tb.sv
`timescale 1ns/1ps
module mgpio_port_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] bus_addr = '0;
   logic        bus_we = 1'b0;
   logic        bus_re = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [7:0]  pin_in = '0;
   logic [7:0]  pin_out;
   logic [7:0]  pin_oe;

   always #2.5 clk = ~clk;

   mgpio_port dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_re(bus_re), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
   );

   typedef struct {
      logic [31:0] exp;
      string       req;
   } sb_item_t;

   sb_item_t sb_q[$];
   int checks = 0;
   int fails  = 0;

   // Bench model of the port state
   logic [7:0] m_out = '0;
   logic [7:0] m_dir = '0;
   logic [7:0] m_pins = '0;   // pin_in level seen by the synchronizer output

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   // Monitor: pops one expected item for every read the driver issued
   always @(negedge clk) begin
      if (sb_q.size() > 0) begin
         sb_item_t it;
         it = sb_q.pop_front();
         check(it.req, bus_rdata, it.exp);
      end
   end

   function automatic logic [31:0] model_read(logic [11:0] a);
      logic [7:0] lvl;
      lvl = (m_dir & m_out) | (~m_dir & m_pins);
      if (a[11:10] == 2'b00)      return {24'h0, lvl & a[9:2]};
      else if (a[11:2] == 10'h100) return {24'h0, m_dir};
      else                         return 32'h0;
   endfunction

   // Driver: one bus cycle; read expectation is queued before the model updates
   task automatic bus_cycle(logic [11:0] a, logic we, logic re, logic [31:0] wd,
                            bit chk, string req);
      @(negedge clk);
      bus_addr = a; bus_we = we; bus_re = re; bus_wdata = wd;
      @(posedge clk);
      if (chk) sb_q.push_back('{exp: (re ? model_read(a) : 32'h0), req: req});
      if (we && a[11:10] == 2'b00) m_out = (m_out & ~a[9:2]) | (wd[7:0] & a[9:2]);
      else if (we && a[11:2] == 10'h100) m_dir = wd[7:0];
      #1;
      bus_we = 1'b0; bus_re = 1'b0;
   endtask

   task automatic wr(logic [11:0] a, logic [31:0] wd);
      bus_cycle(a, 1'b1, 1'b0, wd, 1'b0, "");
   endtask

   task automatic rd(logic [11:0] a, string req);
      bus_cycle(a, 1'b0, 1'b1, 32'h0, 1'b1, req);
   endtask

   task automatic pins_check(string req);
      @(negedge clk);
      check({req, " pin_out"}, {24'h0, pin_out}, {24'h0, m_out});
      check({req, " pin_oe"},  {24'h0, pin_oe},  {24'h0, m_dir});
   endtask

   task automatic set_pins(logic [7:0] v);
      @(negedge clk);
      pin_in = v;
      repeat (3) @(posedge clk);
      m_pins = v;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin : main
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      check("R1 pin_out", {24'h0, pin_out}, 32'h0);
      check("R1 pin_oe", {24'h0, pin_oe}, 32'h0);
      check("R1 rdata", bus_rdata, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 rdata after release", bus_rdata, 32'h0);

      // R5: direction write, pin_oe follows, readback
      wr(12'h400, 32'h0000_00FF);
      pins_check("R5");
      rd(12'h400, "R5 dir readback");

      // R2: full-port write, then masked set and clear
      wr(12'h3FC, 32'h0000_00A5);
      pins_check("R2 full write");
      wr(12'h03C, 32'h0000_00FF);            // mask 0x0F, set
      pins_check("R2 masked set");
      wr(12'h3C0, 32'h0000_0000);            // mask 0xF0, clear
      pins_check("R2 masked clear");
      wr(12'h000, 32'h0000_00FF);            // mask 0x00: no pin touched
      pins_check("R2 empty mask");
      wr(12'h1AA, 32'hFFFF_FF00);            // mask 0x6A, bits [1:0]=2 ignored
      pins_check("R9 byte lanes and high wdata");

      // R3 / R4: masked reads of driven outputs
      rd(12'h0CC, "R3 masked read 0x33");
      rd(12'h3FC, "R4 full read outputs");
      rd(12'h002, "R3 zero mask read");

      // R4: mixed directions with synchronized inputs
      wr(12'h400, 32'h0000_000F);
      pins_check("R5 dir 0x0F");
      set_pins(8'h9C);
      rd(12'h3FC, "R4 mixed read");
      rd(12'h3C0, "R4 input nibble read");

      // R6: synchronizer latency
      @(posedge clk); #1 pin_in = 8'h63;
      rd(12'h3FC, "R6 edge k old level");
      rd(12'h3FC, "R6 edge k+1 old level");
      m_pins = 8'h63;
      rd(12'h3FC, "R6 edge k+2 new level");

      // R7: unmapped accesses
      wr(12'h404, 32'h0000_00FF);
      pins_check("R7 write 0x404");
      wr(12'h800, 32'h0000_00FF);
      pins_check("R7 write 0x800");
      rd(12'h404, "R7 read 0x404");
      rd(12'hFFC, "R7 read 0xFFC");

      // R8: read and write in the same cycle return the pre-write value
      bus_cycle(12'h3FC, 1'b1, 1'b1, 32'h0000_0055, 1'b1, "R8 read with write");
      pins_check("R8 write applied");
      rd(12'h3FC, "R8 read after write");
      bus_cycle(12'h3FC, 1'b0, 1'b0, 32'h0, 1'b1, "R8 idle cycle zero");

      repeat (3) @(posedge clk);
      @(negedge clk);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule